// File: doc/BRIEF.md
# Fracturable Eight-Input Logic Cell

This block is one configurable logic cell for a small programmable-fabric model. It takes eight data inputs and produces two results. A 68-bit configuration word sets its behaviour. That word holds a 64-entry truth table, a two-bit mode field and one output-select bit for each result. The mode makes the cell act in one of four ways:

- a single lookup table of six inputs;
- a seven-input function, formed by choosing between two five-input halves with a seventh input;
- two independent lookup tables that share some inputs, driving separate outputs;
- a two-bit ripple adder whose operands come from four small lookup tables.

The configuration is loaded serially. While the shift enable is high, one bit enters each cycle, most significant first. The chain's last bit leaves on a pin so that cells can be chained. Each result feeds a register with a synchronous clear and a clock enable. Each output pin then presents either the combinational value or the registered value, as its select bit chooses.

Top module: `flex_cell`

## Requirements
- R1: While rst_n is low, the configuration word and both registers are cleared, so after reset comb_out, y_out, cfg_out and carry_out all read 0.
- R2: On each clock edge with cfg_en high, the configuration word moves up by one bit and cfg_in enters bit 0. After 68 such cycles, the first bit shifted in sits in bit 67. cfg_out always shows bit 67. With cfg_en low the word holds. Layout: bits 67:66 mode, bit 65 select for output 1, bit 64 select for output 0, bits 63:0 table T.
- R3: In mode 0, both combinational outputs equal T[din[5:0]], and din[7:6] have no effect.
- R4: In mode 1, both combinational outputs equal T[32+din[4:0]] when din[6] is 1 and T[din[4:0]] when it is 0, and din[7] and din[5] have no effect.
- R5: In mode 2, comb_out[0] = T[din[4:0]] and comb_out[1] = T[32+din[7:3]]. The two tables share din[4:3], so a five-input and a three-input function (din[7:5]) or two four-input functions (din[3:0], din[7:4]) need no shared pin.
- R6: In mode 3, adder bit 0 adds T[din[3:0]], T[16+din[3:0]] and carry_in. Adder bit 1 adds T[32+din[7:4]], T[48+din[7:4]] and the carry of bit 0. The sums drive comb_out[0] and comb_out[1], and the carry of bit 1 drives carry_out.
- R7: In modes 0, 1 and 2, carry_out is 0.
- R8: At each clock edge each register clears when sclr is 1, whether or not ce is high. Otherwise it loads its combinational value when ce is 1, and holds when ce is 0.
- R9: y_out[i] equals the register of output i when select bit i is 1, and comb_out[i] when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_in | input | 1 | Serial configuration data |
| cfg_out | output | 1 | Last bit of the configuration chain |
| din | input | 8 | Data inputs |
| carry_in | input | 1 | Carry into adder bit 0 |
| ce | input | 1 | Register clock enable |
| sclr | input | 1 | Synchronous register clear |
| comb_out | output | 2 | Combinational results |
| y_out | output | 2 | Selected results (combinational or registered) |
| carry_out | output | 1 | Carry out of adder bit 1 |

## Verification
The synchronous clear and the clock enable can both be active in the same cycle. The clear must then win, even though the enable asks the register to load a fresh lookup result. During every input sweep the bench raises the clear on about one cycle in eight and the enable on three cycles in four, so the two coincide many times in every mode. A reference model tracks the register state and judges the registered outputs on every clock. A second overlap comes from configuration loading: the table shifts while the combinational outputs are live, and the model follows each shifted bit.

// File: rtl/flex_cell_pkg.sv
package flex_cell_pkg;
    localparam int DIN_W  = 8;
    localparam int TBL_W  = 64;
    localparam int NOUT   = 2;
    localparam int MODE_W = 2;
    localparam int CFG_W  = TBL_W + NOUT + MODE_W;
    localparam int HALF_W = TBL_W / 2;
    localparam int QTR_W  = TBL_W / 4;
    localparam int NQTR   = 4;
    localparam int NADD   = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_L6    = 2'd0,
        MODE_L7    = 2'd1,
        MODE_SPLIT = 2'd2,
        MODE_ARITH = 2'd3
    } cell_mode_e;

    typedef struct packed {
        cell_mode_e        mode;
        logic [NOUT-1:0]   rsel;
        logic [TBL_W-1:0]  tbl;
    } cell_cfg_t;
endpackage

// File: rtl/flex_cfg_chain.sv
module flex_cfg_chain #(
    parameter int WIDTH = 68
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             shift_in,
    output logic [WIDTH-1:0] word,
    output logic             shift_out
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.bits = {st_q.bits[WIDTH-2:0], shift_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word      = st_q.bits;
    assign shift_out = st_q.bits[WIDTH-1];
endmodule

// File: rtl/flex_lut_core.sv
module flex_lut_core
    import flex_cell_pkg::*;
(
    input  cell_mode_e              mode,
    input  logic [TBL_W-1:0]        tbl,
    input  logic [DIN_W-1:0]        din,
    input  logic                    carry_in,
    output logic [NOUT-1:0]         comb,
    output logic                    carry_out
);
    logic [NQTR-1:0]  qv;
    logic [NADD:0]    cy;
    logic [NADD-1:0]  sum;
    logic [4:0]       hi_idx;
    logic             lo_bit, hi_bit, full_bit;

    // quarter tables: lower pair indexed by din[3:0], upper pair by din[7:4]
    for (genvar g = 0; g < NQTR; g++) begin : g_qtr
        logic [QTR_W-1:0] slice;
        logic [3:0]       idx;
        assign slice = tbl[g*QTR_W +: QTR_W];
        if (g < NQTR/2) begin : g_lo
            assign idx = din[3:0];
        end else begin : g_hi
            assign idx = din[7:4];
        end
        assign qv[g] = slice[idx];
    end

    // ripple adder bits
    assign cy[0] = carry_in;
    for (genvar a = 0; a < NADD; a++) begin : g_add
        logic op_a, op_b;
        assign op_a       = qv[2*a];
        assign op_b       = qv[2*a+1];
        assign sum[a]     = op_a ^ op_b ^ cy[a];
        assign cy[a+1]    = (op_a & op_b) | (cy[a] & (op_a ^ op_b));
    end

    always_comb begin
        hi_idx   = (mode == MODE_SPLIT) ? din[7:3] : din[4:0];
        lo_bit   = tbl[{1'b0, din[4:0]}];
        hi_bit   = tbl[{1'b1, hi_idx}];
        full_bit = tbl[din[5:0]];
        carry_out = 1'b0;
        unique case (mode)
            MODE_L6: begin
                comb = {NOUT{full_bit}};
            end
            MODE_L7: begin
                comb = {NOUT{din[6] ? hi_bit : lo_bit}};
            end
            MODE_SPLIT: begin
                comb = {hi_bit, lo_bit};
            end
            default: begin
                comb      = sum;
                carry_out = cy[NADD];
            end
        endcase
    end
endmodule

// File: rtl/flex_reg_pair.sv
module flex_reg_pair #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             sclr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] r;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sclr) begin
            st_d.r = '0;
        end else if (ce) begin
            st_d.r = d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.r;
endmodule

// File: rtl/flex_cell.sv
module flex_cell
    import flex_cell_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_in,
    output logic             cfg_out,
    input  logic [DIN_W-1:0] din,
    input  logic             carry_in,
    input  logic             ce,
    input  logic             sclr,
    output logic [NOUT-1:0]  comb_out,
    output logic [NOUT-1:0]  y_out,
    output logic             carry_out
);
    logic [CFG_W-1:0] cfg_word;
    cell_cfg_t        cfg_s;
    logic [NOUT-1:0]  reg_q_w;

    flex_cfg_chain #(.WIDTH(CFG_W)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (cfg_en),
        .shift_in  (cfg_in),
        .word      (cfg_word),
        .shift_out (cfg_out)
    );

    assign cfg_s = cell_cfg_t'(cfg_word);

    flex_lut_core u_core (
        .mode      (cfg_s.mode),
        .tbl       (cfg_s.tbl),
        .din       (din),
        .carry_in  (carry_in),
        .comb      (comb_out),
        .carry_out (carry_out)
    );

    flex_reg_pair #(.WIDTH(NOUT)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .sclr  (sclr),
        .d     (comb_out),
        .q     (reg_q_w)
    );

    for (genvar o = 0; o < NOUT; o++) begin : g_osel
        assign y_out[o] = cfg_s.rsel[o] ? reg_q_w[o] : comb_out[o];
    end
endmodule

// File: rtl/flex_cell_chk.sv
module flex_cell_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_en,
    input logic        cfg_in,
    input logic        ce,
    input logic        sclr,
    input logic [1:0]  comb_out,
    input logic        carry_out,
    input logic [67:0] cfg_word,
    input logic [1:0]  reg_bits
);
    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> cfg_word[0] == $past(cfg_in)); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_word)); // R2
    AST_L6_TWIN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_word[67:66] == 2'd0 |-> comb_out[0] == comb_out[1]); // R3
    AST_CARRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_word[67:66] != 2'd3 |-> !carry_out); // R7
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sclr |=> reg_bits == 2'b00); // R8
    AST_CE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclr && ce) |=> reg_bits == $past(comb_out)); // R8
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclr && !ce) |=> $stable(reg_bits)); // R8
endmodule

bind flex_cell flex_cell_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_in    (cfg_in),
    .ce        (ce),
    .sclr      (sclr),
    .comb_out  (comb_out),
    .carry_out (carry_out),
    .cfg_word  (cfg_word),
    .reg_bits  (reg_q_w)
);

// File: tb/flex_cell_test.sv
`timescale 1ns/1ps
module flex_cell_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0, cfg_in = 1'b0;
    logic       cfg_out;
    logic [7:0] din = '0;
    logic       carry_in = 1'b0, ce = 1'b0, sclr = 1'b0;
    logic [1:0] comb_out, y_out;
    logic       carry_out;

    int compared = 0;
    int mismatched = 0;
    logic        done = 1'b0;

    // reference state
    logic [67:0] m_cfg = '0;
    logic [1:0]  m_reg = '0;

    always #2.5 clk = ~clk;

    flex_cell uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in),
        .cfg_out(cfg_out), .din(din), .carry_in(carry_in), .ce(ce),
        .sclr(sclr), .comb_out(comb_out), .y_out(y_out), .carry_out(carry_out)
    );

    function automatic logic [2:0] ref_eval(logic [67:0] c, logic [7:0] d, logic ci);
        int md, s0, s1, c1;
        logic [63:0] t;
        logic o0, o1, co;
        md = int'(c[67:66]);
        t  = c[63:0];
        co = 1'b0;
        if (md == 0) begin
            o0 = t[int'(d[5:0])];
            o1 = o0;
        end else if (md == 1) begin
            o0 = d[6] ? t[32 + int'(d[4:0])] : t[int'(d[4:0])];
            o1 = o0;
        end else if (md == 2) begin
            o0 = t[int'(d[4:0])];
            o1 = t[32 + int'(d[7:3])];
        end else begin
            s0 = int'(t[int'(d[3:0])]) + int'(t[16 + int'(d[3:0])]) + int'(ci);
            c1 = s0 / 2;
            s1 = int'(t[32 + int'(d[7:4])]) + int'(t[48 + int'(d[7:4])]) + c1;
            o0 = s0[0];
            o1 = s1[0];
            co = (s1 >= 2);
        end
        return {co, o1, o0};
    endfunction

    task automatic compare_now();
        logic [2:0] e;
        logic [1:0] ey;
        string rq;
        e = ref_eval(m_cfg, din, carry_in);
        for (int i = 0; i < 2; i++) ey[i] = m_cfg[64+i] ? m_reg[i] : e[i];
        compared++;
        case (m_cfg[67:66])
            2'd0: rq = "R3";
            2'd1: rq = "R4";
            2'd2: rq = "R5";
            default: rq = "R6";
        endcase
        if (comb_out !== e[1:0]) begin
            mismatched++;
            $display("FAIL %s comb_out actual=%b expected=%b din=%h", rq, comb_out, e[1:0], din);
        end else if (carry_out !== e[2]) begin
            mismatched++;
            $display("FAIL %s carry_out actual=%b expected=%b", (m_cfg[67:66] == 2'd3) ? "R6" : "R7",
                     carry_out, e[2]);
        end else if (y_out !== ey) begin
            mismatched++;
            $display("FAIL R8 or R9 y_out actual=%b expected=%b", y_out, ey);
        end else if (cfg_out !== m_cfg[67]) begin
            mismatched++;
            $display("FAIL R2 cfg_out actual=%b expected=%b", cfg_out, m_cfg[67]);
        end
    endtask

    // one clock: inputs already driven at the falling edge
    task automatic step();
        logic [2:0] e;
        #1;
        compare_now();
        e = ref_eval(m_cfg, din, carry_in);
        @(posedge clk);
        if (sclr) m_reg = 2'b00;
        else if (ce) m_reg = e[1:0];
        if (cfg_en) m_cfg = {m_cfg[66:0], cfg_in};
        @(negedge clk);
    endtask

    task automatic load_cfg(logic [67:0] w);
        for (int i = 67; i >= 0; i--) begin
            cfg_en = 1'b1; cfg_in = w[i]; ce = 1'b0; sclr = 1'b0;
            din = 8'($urandom); carry_in = 1'($urandom);
            step();
        end
        cfg_en = 1'b0; cfg_in = 1'b0;
    endtask

    task automatic sweep(int n);
        for (int k = 0; k < n; k++) begin
            din      = 8'(k);
            carry_in = 1'(k >> 8);
            ce       = ($urandom % 4) != 0;
            sclr     = ($urandom % 8) == 0;
            step();
        end
        ce = 1'b0; sclr = 1'b0;
    endtask

    initial begin
        #500000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports
        din = 8'hA5; carry_in = 1'b1;
        #1;
        compared++;
        if (comb_out !== 2'b00 || y_out !== 2'b00 || cfg_out !== 1'b0 || carry_out !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 reset outputs actual=%b%b%b%b expected=0000",
                     comb_out, y_out, cfg_out, carry_out);
        end
        @(negedge clk);
        for (int rs = 0; rs < 4; rs++) begin
            for (int md = 0; md < 4; md++) begin
                logic [67:0] w;
                w = {2'(md), 2'(rs), $urandom, $urandom};
                load_cfg(w);
                // R2: after the full load the model and the design hold the same word
                sweep(md == 3 ? 512 : 256);
                // hold interval: registers must keep their value (R8)
                din = 8'($urandom);
                step();
                step();
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule